// File: doc/BRIEF.md
# Receive Descriptor Ring Write-back Engine

This block stores received Ethernet frames into host memory buffers. Software keeps a ring of 16-byte descriptors in shared memory. Each descriptor holds four 32-bit words: a status/control word, a tag word, the low buffer address and the high buffer address. Software gives a descriptor to the block by setting its ownership bit and putting the buffer capacity in the low bits of the status word. The block fetches the current descriptor before a frame arrives and checks that it owns it. It then writes each incoming byte into that buffer. At the end of the frame it writes back one status word that returns the descriptor to software with the length and the error flags.

The byte stream has no backpressure. A frame is accepted only if a descriptor has already been fetched and is owned when the frame's first byte arrives. Otherwise the whole frame is discarded and a missed-frame counter advances. The ring has no fixed count: the block moves 16 bytes forward after each descriptor and returns to the 256-byte-aligned ring base after a descriptor marked end-of-ring. Buffer capacity is capped at 1536 bytes whatever the status word says. The memory port is word addressed. Read data must be present on `mem_rdata` during the cycle the read request is shown.

Top module: `rx_ring_writeback`

## Requirements
- R1: During and after reset, with `en` low, `mem_req` stays 0 and `missed_count` is 0.
- R2: The block reads a descriptor's status word (word offset 0) and then its low buffer address (word offset 2). Byte n of an accepted frame is written to byte address buffer+n as a single-byte write. The enable of that write has only lane (address mod 4) set, so byte 0 of a word is bits 7:0.
- R3: At frame end the block writes only the descriptor's status word, with byte enables 4'hF. In that word bit 31 (own) is 0, bits 29 and 28 (first and last segment) are 1, and bits 12:0 hold the frame's byte count including its 4 CRC bytes.
- R4: The error inputs are sampled with the last byte. CRC error sets status bit 19, runt sets bit 20 and watchdog timeout sets bit 22. Bit 21, the error summary, is set whenever any error bit is set or the buffer overflowed.
- R5: Bytes beyond the buffer size (status bits 12:0 at fetch) are not written. In that case the length field is clamped to the size and bit 21 is set. A frame exactly as long as the buffer has no overflow.
- R6: A frame whose first byte arrives when no owned descriptor is ready is dropped whole. It causes no memory write, leaves the descriptor untouched and adds exactly one to `missed_count`. This applies both to a descriptor not owned and to a frame that follows the previous one too closely. A descriptor that is not owned is polled until software sets bit 31.
- R7: After write-back the next descriptor is at the previous one plus 16 bytes. If the used descriptor had bit 30 (end-of-ring) set, the next one is at the ring base instead, and bit 30 is copied into the written-back status.
- R8: While `en` is low the block fetches nothing and ignores frames: it writes nothing and does not count them. Enabling again restarts at the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receive enable |
| ring_base | input | 32 | Ring base byte address (bits 7:0 ignored) |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of frame |
| rx_crc_err | input | 1 | CRC error, valid with last byte |
| rx_runt | input | 1 | Runt frame, valid with last byte |
| rx_wdt | input | 1 | Receive watchdog timeout, valid with last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while the read request is presented |
| missed_count | output | 16 | Dropped-frame counter |

## Verification
The hardest case to create from the ports is a frame that starts in the few cycles between a write-back and the next descriptor becoming ready. The bench creates it by sending two frames back to back, with no idle cycle between them. It also hands over a descriptor while the block is still polling it, to show that polling picks up the ownership change. Random frame lengths and buffer sizes land on both sides of the buffer boundary and cover several trips around the ring.

// File: rtl/rx_ring_writeback.sv
module rx_ring_writeback #(
  parameter int CNT_W   = 14,
  parameter int MAX_BUF = 1536,
  parameter int MISS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [31:0]       ring_base,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_crc_err,
  input  logic              rx_runt,
  input  logic              rx_wdt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [29:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] missed_count
);
  localparam int LEN_W = 13;
  localparam logic [31:0] DESC_STEP = 32'd16;

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_BUF, S_READY, S_RECV, S_WB} state_t;
  state_t state;

  logic [31:0]      off_q, buf_q;
  logic [LEN_W-1:0] size_q;
  logic [CNT_W-1:0] cnt_q;
  logic             eor_q, dropping, e_crc, e_runt, e_wdt;

  wire unused_base = ^ring_base[7:0];
  wire [31:0] desc_addr = {ring_base[31:8], 8'h00} + off_q;

  wire frame_start = rx_valid && state != S_RECV && !dropping;
  wire take        = frame_start && state == S_READY && en;
  wire miss        = frame_start && !take && en;
  wire byte_in     = take || (rx_valid && state == S_RECV);

  wire [CNT_W-1:0] idx     = take ? '0 : cnt_q;
  wire [CNT_W-1:0] cnt_nxt = (&idx) ? idx : idx + CNT_W'(1);
  wire             room    = idx < CNT_W'(size_q);
  wire [31:0]      baddr   = buf_q + 32'(idx);

  wire [LEN_W-1:0] fetched_size = (mem_rdata[LEN_W-1:0] > LEN_W'(MAX_BUF)) ?
                                  LEN_W'(MAX_BUF) : mem_rdata[LEN_W-1:0];

  wire             ovf    = cnt_q > CNT_W'(size_q);
  wire [LEN_W-1:0] wb_len = ovf ? size_q : cnt_q[LEN_W-1:0];
  wire             res    = e_crc | e_runt | e_wdt | ovf;
  wire [31:0] status_wb = {1'b0, eor_q, 2'b11, 5'b0, e_wdt, res, e_runt, e_crc, 6'b0, wb_len};

  assign missed_count = missed_q;
  logic [MISS_W-1:0] missed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      off_q    <= '0;
      buf_q    <= '0;
      size_q   <= '0;
      cnt_q    <= '0;
      eor_q    <= 1'b0;
      dropping <= 1'b0;
      e_crc    <= 1'b0;
      e_runt   <= 1'b0;
      e_wdt    <= 1'b0;
      missed_q <= '0;
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_be   <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      mem_be  <= '0;

      case (state)
        S_IDLE: begin
          if (en) begin
            mem_req  <= 1'b1;
            mem_addr <= desc_addr[31:2];
            state    <= S_STAT;
          end else begin
            off_q <= '0;
          end
        end
        S_STAT: begin
          if (!en) begin
            state <= S_IDLE;
          end else if (mem_rdata[31]) begin
            eor_q    <= mem_rdata[30];
            size_q   <= fetched_size;
            mem_req  <= 1'b1;
            mem_addr <= desc_addr[31:2] + 30'd2;
            state    <= S_BUF;
          end else begin
            state <= S_IDLE;
          end
        end
        S_BUF: begin
          buf_q <= mem_rdata;
          state <= en ? S_READY : S_IDLE;
        end
        S_READY: if (!en) state <= S_IDLE;
        S_WB: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_be    <= 4'hF;
          mem_addr  <= desc_addr[31:2];
          mem_wdata <= status_wb;
          off_q     <= eor_q ? '0 : off_q + DESC_STEP;
          state     <= S_IDLE;
        end
        default: ;
      endcase

      if (byte_in) begin
        cnt_q <= cnt_nxt;
        if (room) begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= baddr[31:2];
          mem_be    <= 4'b0001 << baddr[1:0];
          mem_wdata <= {4{rx_data}};
        end
        if (rx_last) begin
          e_crc  <= rx_crc_err;
          e_runt <= rx_runt;
          e_wdt  <= rx_wdt;
          state  <= S_WB;
        end else begin
          state <= S_RECV;
        end
      end

      if (frame_start && !take)
        dropping <= !rx_last;
      else if (dropping && rx_valid && rx_last)
        dropping <= 1'b0;

      if (miss) missed_q <= missed_q + MISS_W'(1);
    end
  end

  logic [1:0] wr_lane;
  always_comb begin
    case (mem_be)
      4'b0010: wr_lane = 2'd1;
      4'b0100: wr_lane = 2'd2;
      4'b1000: wr_lane = 2'd3;
      default: wr_lane = 2'd0;
    endcase
  end
  wire [31:0] wr_byte = {mem_addr, wr_lane};

  p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($onehot(mem_be) || mem_be == 4'hF));

  p_bytes_in_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hF) |-> ((wr_byte - buf_q) < 32'(size_q)));

  p_wb_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hF) |->
      (!mem_wdata[31] && mem_wdata[29] && mem_wdata[28] && mem_wdata[12:0] <= size_q));

  p_res_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hF && (mem_wdata[22] || mem_wdata[20] || mem_wdata[19]))
      |-> mem_wdata[21]);

  p_missed_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_count != $past(missed_count)) |-> (missed_count == $past(missed_count) + MISS_W'(1)));

  p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dropping && $past(dropping)) |-> !(mem_req && mem_we && mem_be != 4'hF));
endmodule

// File: tb/rx_ring_writeback_test.sv
module rx_ring_writeback_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0, rx_runt = 1'b0, rx_wdt = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic [15:0] missed_count;

  rx_ring_writeback uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ring_base(ring_base),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_crc_err(rx_crc_err), .rx_runt(rx_runt), .rx_wdt(rx_wdt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .missed_count(missed_count));

  always #5 clk = ~clk;

  logic [31:0] mem [0:255];
  logic tb_we = 1'b0;
  logic [7:0] tb_wa = 8'h0;
  logic [31:0] tb_wd = 32'h0;
  assign mem_rdata = mem_req ? mem[mem_addr[7:0]] : 32'h0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  int checks = 0, fails = 0, cur = 0;
  logic [7:0] fb [0:63];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input int wa, input logic [31:0] wd);
    tb_wa = 8'(wa); tb_wd = wd; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic int dword(input int d); return 64 + 4*d; endfunction
  function automatic int bufb(input int d); return 32'h200 + 64*d; endfunction
  function automatic logic [7:0] rdb(input int a);
    return 8'(mem[(a >> 2) & 255] >> (8*(a % 4)));
  endfunction
  function automatic logic [31:0] armed(input int d, input int size, input bit own);
    return {own, d == 3, 17'b0, 13'(size)};
  endfunction
  function automatic logic [31:0] exp_stat(input int d, input int size, input int len,
                                           input bit c, input bit r, input bit w);
    int l; bit ovf, res;
    l = (len > size) ? size : len;
    ovf = len > size;
    res = c | r | w | ovf;
    return {1'b0, d == 3, 2'b11, 5'b0, w, res, r, c, 6'b0, 13'(l)};
  endfunction

  task automatic arm(input int d, input int size);
    for (int w = 0; w < 16; w++) poke(128 + 16*d + w, 32'hEEEEEEEE);
    poke(dword(d) + 2, bufb(d));
    poke(dword(d), armed(d, size, 1'b1));
  endtask

  task automatic send(input int len, input bit c, input bit r, input bit w, input bit fresh);
    for (int i = 0; i < len; i++) begin
      if (fresh) fb[i] = 8'($urandom);
      rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == len-1);
      rx_crc_err = (i == len-1) & c; rx_runt = (i == len-1) & r; rx_wdt = (i == len-1) & w;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_runt = 1'b0; rx_wdt = 1'b0;
  endtask

  task automatic check_frame(input int d, input int size, input int len,
                             input bit c, input bit r, input bit w);
    int bad, n;
    string tag;
    tag = (c | r | w) ? "R4" : (len > size) ? "R5" : "R3";
    chk(mem[dword(d)] == exp_stat(d, size, len, c, r, w), tag, mem[dword(d)],
        exp_stat(d, size, len, c, r, w));
    bad = 0;
    n = (len > size) ? size : len;
    for (int i = 0; i < n; i++) if (rdb(bufb(d) + i) != fb[i]) bad++;
    chk(bad == 0, "R2 buffer bytes", bad, 0);
    chk(rdb(bufb(d) + size) == 8'hEE, "R5 byte past buffer", rdb(bufb(d) + size), 8'hEE);
  endtask

  task automatic do_frame(input int size, input int len, input bit c, input bit r, input bit w);
    arm(cur, size);
    idle(8);
    send(len, c, r, w, 1'b1);
    idle(8);
    check_frame(cur, size, len, c, r, w);
    cur = (cur + 1) % 4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int m0, sz, ln;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) poke(i, 32'h0);
    chk(mem_req == 1'b0 && missed_count == 16'd0, "R1 in reset", {mem_req, missed_count}, 0);
    rst_n = 1'b1;
    idle(3);
    chk(mem_req == 1'b0 && missed_count == 16'd0, "R1 after reset", {mem_req, missed_count}, 0);

    // R8: disabled block ignores a frame
    arm(0, 40);
    send(10, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(6);
    chk(missed_count == 16'd0, "R8 no count while disabled", missed_count, 0);
    chk(mem[dword(0)] == armed(0, 40, 1'b1), "R8 descriptor untouched", mem[dword(0)], armed(0, 40, 1'b1));
    chk(rdb(bufb(0)) == 8'hEE, "R8 buffer untouched", rdb(bufb(0)), 8'hEE);

    en = 1'b1;
    do_frame(40, 20, 1'b0, 1'b0, 1'b0);
    do_frame(40, 40, 1'b0, 1'b0, 1'b0);   // R5 exact fit
    do_frame(40, 45, 1'b0, 1'b0, 1'b0);   // R5 overflow
    do_frame(40, 1, 1'b1, 1'b0, 1'b0);    // R4 crc, R7 end-of-ring kept
    chk(mem[dword(3)][30] == 1'b1, "R7 end-of-ring preserved", mem[dword(3)], 32'h40000000);
    do_frame(30, 12, 1'b0, 1'b1, 1'b0);   // R4 runt, wrap to base
    chk(mem[dword(0)][31] == 1'b0 && mem[dword(0)][12:0] == 13'd12, "R7 wrap to base",
        mem[dword(0)], exp_stat(0, 30, 12, 0, 1, 0));
    do_frame(30, 50, 1'b0, 1'b0, 1'b1);   // R4 watchdog with overflow

    for (int k = 0; k < 16; k++) begin
      sz = 8 + ($urandom % 53);
      ln = 1 + ($urandom % 63);
      do_frame(sz, ln, ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    // R6: descriptor not owned, then handed over while polled
    for (int w = 0; w < 16; w++) poke(128 + 16*cur + w, 32'hEEEEEEEE);
    poke(dword(cur), armed(cur, 25, 1'b0));
    idle(8);
    m0 = missed_count;
    send(12, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(8);
    chk(missed_count == 16'(m0 + 1), "R6 missed count", missed_count, m0 + 1);
    chk(mem[dword(cur)] == armed(cur, 25, 1'b0), "R6 descriptor untouched",
        mem[dword(cur)], armed(cur, 25, 1'b0));
    chk(rdb(bufb(cur)) == 8'hEE, "R6 no buffer write", rdb(bufb(cur)), 8'hEE);
    do_frame(25, 12, 1'b0, 1'b0, 1'b0);   // R6 polling sees ownership

    // R6: frame following too closely is dropped
    arm(cur, 20);
    arm((cur + 1) % 4, 30);
    idle(8);
    m0 = missed_count;
    send(10, 1'b0, 1'b0, 1'b0, 1'b1);
    send(10, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(8);
    check_frame(cur, 20, 10, 1'b0, 1'b0, 1'b0);
    chk(missed_count == 16'(m0 + 1), "R6 back-to-back dropped", missed_count, m0 + 1);
    cur = (cur + 1) % 4;
    chk(mem[dword(cur)] == armed(cur, 30, 1'b1), "R6 next descriptor kept",
        mem[dword(cur)], armed(cur, 30, 1'b1));
    send(15, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(8);
    check_frame(cur, 30, 15, 1'b0, 1'b0, 1'b0);
    cur = (cur + 1) % 4;

    // R8: re-enable restarts at ring base
    if (cur == 0) do_frame(20, 8, 1'b0, 1'b0, 1'b0);
    en = 1'b0;
    idle(4);
    chk(mem_req == 1'b0, "R8 no fetch while disabled", mem_req, 0);
    en = 1'b1;
    cur = 0;
    m0 = missed_count;
    do_frame(30, 20, 1'b0, 1'b0, 1'b0);
    chk(missed_count == 16'(m0), "R8 restart at base", missed_count, m0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule